// File: doc/BRIEF.md
# Stereo Serial Audio Port with Selectable Justification

This block is the master side of a two-channel serial audio link. Its registers run on the bit clock, which the surrounding chip supplies. The block drives a word-select line with a 50% duty cycle. A left word is sent while the line is low and a right word while it is high. Each word is shifted out MSB first. Received bits are shifted in on the same slots.

Three configuration inputs set the timing. The first sets how many bit clocks a half frame lasts. The second sets how many bits a word carries. The third sets how many words make up one buffer. A justification select picks where the MSB falls. In standard timing it comes one bit clock after the word-select edge. In left-justified timing it comes in the same bit clock as the edge. The data output is released to high impedance whenever no word bit is being driven.

Transmit words are read from a parallel buffer input. Received words are presented on a parallel buffer output. A single-cycle interrupt pulse marks each completed buffer. An enable input restarts framing, so every run begins with a left word taken from buffer position 0.

Top module: `i2s_port`

## Requirements
- R1: `ws_o` toggles every He bit clocks while enabled, giving a 50% duty cycle. He is the larger of `half_len_i`+1 and the word size in bits.
- R2: The word size in bits is `word_size_i`+1. Any setting below 4 bits is raised to 4.
- R3: With `justify_left_i`=0, the word MSB is driven in the second bit clock of its half frame. The remaining bits follow MSB first, one per bit clock.
- R4: With `justify_left_i`=1, the word MSB is driven in the first bit clock of its half frame, the same cycle in which `ws_o` changes.
- R5: `sdo_oe_o` is high only during the bit clocks that carry a word bit. At all other times `sdo_o` is high impedance.
- R6: The buffer holds `buf_len_i`+1 words. Word k of a buffer is taken from `tx_buf_i[16k+W-1:16k]` (right-aligned, W = word size). The word position advances every half frame and wraps after the last word.
- R7: `sdi_i` is sampled on the rising edge in the same slots that carry transmit bits, MSB first. After the last bit, the word is stored right-aligned, with upper bits zero, in `rx_buf_o[16k+15:16k]` for buffer position k.
- R8: `irq_o` pulses high for exactly one cycle in the cycle after the last bit of the buffer's final word. `rx_buf_o` already holds that word in the same cycle.
- R9: While `enable_i` is low, `ws_o` and `sdo_oe_o` are low and framing is held at its start. The first active cycle after enable rises begins a left word at buffer position 0.
- R10: After reset, `ws_o`, `sdo_oe_o` and `irq_o` are low and every `rx_buf_o` word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, supplied externally |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run framing; low holds the port at frame start |
| justify_left_i | input | 1 | 1 = MSB on the word-select edge, 0 = one bit clock later |
| half_len_i | input | 4 | Half-frame length in bit clocks, minus one |
| word_size_i | input | 4 | Word size in bits, minus one |
| buf_len_i | input | 2 | Words per buffer, minus one |
| tx_buf_i | input | 64 | Four right-aligned 16-bit transmit words |
| sdi_i | input | 1 | Serial data in |
| ws_o | output | 1 | Word select, low = left, high = right |
| sdo_o | output | 1 | Serial data out, high impedance when idle |
| sdo_oe_o | output | 1 | Serial data output drive enable |
| rx_buf_o | output | 64 | Four right-aligned 16-bit received words |
| irq_o | output | 1 | One-cycle pulse per completed buffer |

## Verification
Two cases are hard to reach from the ports. In one, the half frame equals the word size in standard timing, so the LSB of one word lands in the first cycle of the next half frame. In the other, a too-short half-frame or word-size setting must be widened by the clamps. Each directed scenario reaches one of these by its configuration alone: 16-bit words in a 16-cycle half frame, a 3-cycle half frame under 4-bit words, and a 2-bit word request. It then follows every cycle against an independent slot model that predicts word select, drive enable, data bit and interrupt. The received buffer is compared at every interrupt.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  typedef enum logic {
    JUST_STD  = 1'b0,
    JUST_LEFT = 1'b1
  } just_e;

  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_BUF_MAX = 4;
  localparam int unsigned DEF_MIN_W   = 4;
endpackage

// File: rtl/i2s_frame_gen.sv
module i2s_frame_gen #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] he_m1_i,
  input  logic [IDX_W-1:0] blen_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ws_o,
  output logic             wrap_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [IDX_W-1:0] widx_nxt_o
);
  logic             run_q, ws_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] widx_q;

  assign wrap_o     = run_q && (cnt_q >= he_m1_i);
  assign widx_nxt_o = (widx_q >= blen_i) ? '0 : widx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ws_q   <= 1'b0;
      cnt_q  <= '0;
      widx_q <= '0;
    end else if (!enable_i) begin
      run_q  <= 1'b0;
      ws_q   <= 1'b0;
      cnt_q  <= '0;
      widx_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      ws_q   <= ~ws_q;
      widx_q <= widx_nxt_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign ws_o   = ws_q;
  assign widx_o = widx_q;
endmodule

// File: rtl/i2s_tx_path.sv
module i2s_tx_path
  import i2s_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BUF_MAX = 4,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      just_i,
  input  logic                      run_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic                      wrap_i,
  input  logic [IDX_W-1:0]          widx_i,
  input  logic [IDX_W-1:0]          widx_nxt_i,
  input  logic [CNT_W-1:0]          wb_m1_i,
  input  logic [BUF_MAX*DATA_W-1:0] tx_buf_i,
  output logic                      slot_oe_o,
  output logic                      slot_last_o,
  output logic [IDX_W-1:0]          slot_idx_o,
  output logic                      slot_bit_o
);
  logic [DATA_W-1:0] tx_slot [BUF_MAX];
  logic [DATA_W-1:0] tx_word_q;

  for (genvar g = 0; g < BUF_MAX; g++) begin : g_slot
    assign tx_slot[g] = tx_buf_i[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_word_q <= '0;
    else if (!run_i)  tx_word_q <= tx_slot[0];
    else if (wrap_i)  tx_word_q <= tx_slot[widx_nxt_i];
  end

  // left-justified stream; standard timing is this stream one bit clock later
  logic             lj_oe, lj_last, lj_bit;
  logic [CNT_W-1:0] lj_pos;

  assign lj_oe   = run_i && (cnt_i <= wb_m1_i);
  assign lj_last = run_i && (cnt_i == wb_m1_i);
  assign lj_pos  = wb_m1_i - cnt_i;
  assign lj_bit  = tx_word_q[lj_pos];

  logic             dl_oe_q, dl_last_q, dl_bit_q;
  logic [IDX_W-1:0] dl_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_oe_q   <= 1'b0;
      dl_last_q <= 1'b0;
      dl_bit_q  <= 1'b0;
      dl_idx_q  <= '0;
    end else if (!enable_i) begin
      dl_oe_q   <= 1'b0;
      dl_last_q <= 1'b0;
      dl_bit_q  <= 1'b0;
      dl_idx_q  <= '0;
    end else begin
      dl_oe_q   <= lj_oe;
      dl_last_q <= lj_last;
      dl_bit_q  <= lj_bit;
      dl_idx_q  <= widx_i;
    end
  end

  always_comb begin
    if (just_e'(just_i) == JUST_LEFT) begin
      slot_oe_o   = lj_oe;
      slot_last_o = lj_last;
      slot_idx_o  = widx_i;
      slot_bit_o  = lj_bit;
    end else begin
      slot_oe_o   = dl_oe_q;
      slot_last_o = dl_last_q;
      slot_idx_o  = dl_idx_q;
      slot_bit_o  = dl_bit_q;
    end
  end
endmodule

// File: rtl/i2s_rx_path.sv
module i2s_rx_path #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BUF_MAX = 4,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      sdi_i,
  input  logic                      slot_oe_i,
  input  logic                      slot_last_i,
  input  logic [IDX_W-1:0]          slot_idx_i,
  input  logic [CNT_W-1:0]          wb_m1_i,
  input  logic [IDX_W-1:0]          blen_i,
  output logic [BUF_MAX*DATA_W-1:0] rx_buf_o,
  output logic                      irq_o
);
  logic [DATA_W-1:0] sh_q, sh_nxt, wmask;
  logic [DATA_W-1:0] rx_mem_q [BUF_MAX];
  logic              irq_q, take, done;

  assign take   = enable_i && slot_oe_i;
  assign done   = take && slot_last_i;
  assign sh_nxt = {sh_q[DATA_W-2:0], sdi_i};
  assign wmask  = ~({DATA_W{1'b1}} << ({1'b0, wb_m1_i} + 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (take) sh_q <= sh_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= done && (slot_idx_i == blen_i);
  end

  for (genvar g = 0; g < BUF_MAX; g++) begin : g_rx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rx_mem_q[g] <= '0;
      else if (done && (slot_idx_i == IDX_W'(g))) rx_mem_q[g] <= sh_nxt & wmask;
    end
    assign rx_buf_o[g*DATA_W +: DATA_W] = rx_mem_q[g];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2s_port_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned BUF_MAX = DEF_BUF_MAX,
  parameter int unsigned MIN_W   = DEF_MIN_W,
  localparam int unsigned CNT_W  = $clog2(DATA_W),
  localparam int unsigned IDX_W  = $clog2(BUF_MAX),
  localparam int unsigned BUF_W  = BUF_MAX * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             justify_left_i,
  input  logic [CNT_W-1:0] half_len_i,
  input  logic [CNT_W-1:0] word_size_i,
  input  logic [IDX_W-1:0] buf_len_i,
  input  logic [BUF_W-1:0] tx_buf_i,
  input  logic             sdi_i,
  output logic             ws_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [BUF_W-1:0] rx_buf_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] MIN_M1 = CNT_W'(MIN_W - 1);

  logic [CNT_W-1:0] wb_m1, he_m1, cnt;
  logic [IDX_W-1:0] widx, widx_nxt, slot_idx;
  logic             run, wrap, slot_oe, slot_last, slot_bit;

  // clamp: word at least MIN_W bits, half frame at least one word
  assign wb_m1 = (word_size_i < MIN_M1) ? MIN_M1 : word_size_i;
  assign he_m1 = (half_len_i < wb_m1) ? wb_m1 : half_len_i;

  i2s_frame_gen #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .he_m1_i    (he_m1),
    .blen_i     (buf_len_i),
    .run_o      (run),
    .cnt_o      (cnt),
    .ws_o       (ws_o),
    .wrap_o     (wrap),
    .widx_o     (widx),
    .widx_nxt_o (widx_nxt)
  );

  i2s_tx_path #(.DATA_W(DATA_W), .BUF_MAX(BUF_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .just_i      (justify_left_i),
    .run_i       (run),
    .cnt_i       (cnt),
    .wrap_i      (wrap),
    .widx_i      (widx),
    .widx_nxt_i  (widx_nxt),
    .wb_m1_i     (wb_m1),
    .tx_buf_i    (tx_buf_i),
    .slot_oe_o   (slot_oe),
    .slot_last_o (slot_last),
    .slot_idx_o  (slot_idx),
    .slot_bit_o  (slot_bit)
  );

  i2s_rx_path #(.DATA_W(DATA_W), .BUF_MAX(BUF_MAX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .sdi_i       (sdi_i),
    .slot_oe_i   (slot_oe),
    .slot_last_i (slot_last),
    .slot_idx_i  (slot_idx),
    .wb_m1_i     (wb_m1),
    .blen_i      (buf_len_i),
    .rx_buf_o    (rx_buf_o),
    .irq_o       (irq_o)
  );

  assign sdo_oe_o = slot_oe;
  assign sdo_o    = slot_oe ? slot_bit : 1'bz;
endmodule

// File: rtl/i2s_port_chk.sv
module i2s_port_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned BUF_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             justify_left_i,
  input logic [CNT_W-1:0] word_size_i,
  input logic             ws_o,
  input logic             sdo_oe_o,
  input logic [BUF_W-1:0] rx_buf_o,
  input logic             irq_o
);
  logic [CNT_W:0]    wbits;
  logic [DATA_W-1:0] hi_mask;

  assign wbits   = (word_size_i < CNT_W'(3)) ? (CNT_W+1)'(4) : {1'b0, word_size_i} + 1'b1;
  assign hi_mask = {DATA_W{1'b1}} << wbits;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!ws_o && !sdo_oe_o)); // R9

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R8

  AST_LJ_MSB_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (justify_left_i && $past(justify_left_i) && $past(enable_i) && (ws_o != $past(ws_o)))
      |-> sdo_oe_o); // R4

  AST_WS_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws_o) |-> $past(enable_i)); // R1

  AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> $past(enable_i)); // R5

  AST_RX_RIGHT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $stable(word_size_i)) |-> ((rx_buf_o[DATA_W-1:0] & hi_mask) == '0)); // R7
endmodule

bind i2s_port i2s_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BUF_W(BUF_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .justify_left_i (justify_left_i),
  .word_size_i    (word_size_i),
  .ws_o           (ws_o),
  .sdo_oe_o       (sdo_oe_o),
  .rx_buf_o       (rx_buf_o),
  .irq_o          (irq_o)
);

// File: tb/i2s_port_tb.sv
`timescale 1ns/1ps
module i2s_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        just = 1'b0;
  logic [3:0]  half_len = 4'd15;
  logic [3:0]  word_size = 4'd15;
  logic [1:0]  buf_len = 2'd1;
  logic [63:0] tx_buf = '0;
  logic        sdi = 1'b0;
  logic        ws, sdo, sdo_oe, irq;
  logic [63:0] rx_buf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2s_port u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .enable_i       (enable),
    .justify_left_i (just),
    .half_len_i     (half_len),
    .word_size_i    (word_size),
    .buf_len_i      (buf_len),
    .tx_buf_i       (tx_buf),
    .sdi_i          (sdi),
    .ws_o           (ws),
    .sdo_o          (sdo),
    .sdo_oe_o       (sdo_oe),
    .rx_buf_o       (rx_buf),
    .irq_o          (irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tx_word(int k, int seed);
    return ((16'hA5C3 ^ (k * 16'h1357) ^ (seed * 16'h0F1D)) & 16'hFFFF);
  endfunction

  function automatic int rx_word(int k, int seed);
    return ((16'h3C96 ^ (k * 16'h2B41) ^ (seed * 16'h7E05)) & 16'hFFFF);
  endfunction

  task automatic reset_check();
    @(negedge clk);
    chk(ws == 1'b0, "R10 ws after reset", ws, 0);
    chk(sdo_oe == 1'b0, "R10 oe after reset", sdo_oe, 0);
    chk(irq == 1'b0, "R10 irq after reset", irq, 0);
    chk(rx_buf == 64'd0, "R10 rx_buf after reset", int'(rx_buf[31:0]), 0);
  endtask

  // one directed scenario: configure, hold disabled, then run and compare each cycle
  task automatic run_case(input int hl, input int wsz, input int bl, input bit lj,
                          input int ncyc, input int seed, input string tag);
    int wb, he, nb, mask;
    bit irq_exp;
    @(negedge clk);
    enable = 1'b0;
    half_len = 4'(hl);
    word_size = 4'(wsz);
    buf_len = 2'(bl);
    just = lj;
    sdi = 1'b0;
    for (int k = 0; k < 4; k++) tx_buf[k*16 +: 16] = 16'(tx_word(k, seed));
    wb = (wsz + 1 < 4) ? 4 : wsz + 1;      // R2 clamp
    he = (hl + 1 < wb) ? wb : hl + 1;      // R1 clamp
    nb = bl + 1;
    mask = (1 << wb) - 1;
    repeat (3) @(negedge clk);
    chk(ws == 1'b0, {tag, " R9 ws while disabled"}, ws, 0);
    chk(sdo_oe == 1'b0, {tag, " R9 oe while disabled"}, sdo_oe, 0);
    enable = 1'b1;
    irq_exp = 1'b0;
    for (int t = 0; t < ncyc; t++) begin
      int s, w, q, bexp;
      bit oe_exp, last_exp;
      @(negedge clk);
      s = lj ? t : t - 1;
      oe_exp = 1'b0;
      last_exp = 1'b0;
      w = 0;
      q = 0;
      if (s >= 0) begin
        w = s / he;
        q = s % he;
        oe_exp = (q < wb);
        last_exp = (q == wb - 1);
      end
      chk(ws == 1'((t / he) % 2), {tag, " R1/R9 ws"}, ws, (t / he) % 2);
      chk(sdo_oe == oe_exp, {tag, " R5 drive enable"}, sdo_oe, oe_exp);
      if (oe_exp) begin
        bexp = (tx_word(w % nb, seed) >> (wb - 1 - q)) & 1;
        chk(sdo === 1'(bexp), {tag, lj ? " R4/R6/R2 bit" : " R3/R6/R2 bit"}, sdo, bexp);
        sdi = 1'((rx_word(w % nb, seed) >> (wb - 1 - q)) & 1);
      end else begin
        sdi = ~sdi;   // noise outside slots must not reach the buffer
      end
      chk(irq == irq_exp, {tag, " R8 irq"}, irq, irq_exp);
      if (irq_exp) begin
        for (int k = 0; k < nb; k++) begin
          int got = int'(rx_buf[k*16 +: 16]);
          chk(got == (rx_word(k, seed) & mask), {tag, " R7 rx word"}, got, rx_word(k, seed) & mask);
        end
      end
      irq_exp = oe_exp && last_exp && ((w % nb) == nb - 1);
    end
    @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    #1;
    reset_check();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_check();
    run_case(15, 15, 1, 1'b0, 140, 1, "std_w16_h16");   // LSB spills into next half
    run_case(11,  7, 0, 1'b1, 120, 2, "lj_w8_h12");
    run_case( 2,  3, 3, 1'b0, 100, 3, "std_h_clamped");   // R1 clamp
    run_case(15, 11, 2, 1'b1, 200, 4, "lj_w12_b3");
    run_case( 5,  1, 1, 1'b0,  80, 5, "std_w_clamped");   // R2 clamp
    run_case( 9,  9, 3, 1'b1, 120, 6, "lj_restart");       // R9 restart
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule